// File: doc/BRIEF.md
# Memory Mapper Page Registers

This block keeps the four page-select registers of a memory mapper for an 8-bit CPU with a 64KB address space. The CPU address space is split into four 16KB windows. Each window takes its physical page from a register that the CPU writes through one of the I/O ports FCh to FFh. The block turns each CPU memory address into a 20-bit physical RAM address and flags any page that lies above the installed RAM. Those pages read as FFh and cannot be written.

Reads of the mapper ports are made safe for a bus that other mappers may share. When read response is enabled, the block drives all eight bits exactly as they were last written. When it is disabled, the block leaves the data bus alone so that another device can answer. Two configuration inputs set the installed page count and switch read response on or off. Only the low six bits of a register select a physical page, so page numbers from 40h upwards mirror the first 1MB image.

Top module: `mapper_page_unit`

## Requirements
- R1: After reset, the registers for ports FCh, FDh, FEh and FFh hold 03h, 02h, 01h and 00h.
- R2: An I/O write updates register k at the next rising clock edge when `io_addr_i` equals FCh+k, so bits 7:2 must all be 1 and bits 1:0 give k. A write to any other I/O address changes no register.
- R3: When `cfg_rd_en_i` is high and an I/O read targets FCh+k, `io_oe_o` is high in the same cycle. In that cycle `io_rdata_o` carries all eight bits last written to register k, with no bit replaced by a constant.
- R4: `io_oe_o` is low whenever `cfg_rd_en_i` is low, `io_rd_i` is low or the address lies outside FCh to FFh. While `io_oe_o` is low, `io_rdata_o` is 00h.
- R5: `mem_addr_i[15:14]` selects the window. Window 0 is controlled by port FCh and window 3 by port FFh. `phys_addr_o` is {bits 5:0 of that window's register, `mem_addr_i[13:0]`}.
- R6: `ram_valid_o` is high exactly when bits 5:0 of the selected register are below `cfg_pages_i`. The value 48 gives 768KB installed, and 64 gives the full 1MB.
- R7: `mem_rdata_o` equals `ram_rdata_i` when `ram_valid_o` is high and equals FFh when it is low.
- R8: `ram_we_o` is high only when `mem_wr_i` is high and `ram_valid_o` is high. Writes to unpopulated pages are dropped.
- R9: Register bits 7:6 have no effect on `phys_addr_o` or `ram_valid_o`. Pages 40h and above therefore mirror pages 00h to 3Fh, while read-back still returns bits 7:6 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_pages_i | input | 7 | Installed RAM in 16KB pages (0 to 64) |
| cfg_rd_en_i | input | 1 | Enables read response on the mapper ports |
| io_addr_i | input | 8 | Low byte of the I/O address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data, 00h when not driving |
| io_oe_o | output | 1 | Data bus output enable for I/O reads |
| mem_addr_i | input | 16 | CPU memory address |
| mem_wr_i | input | 1 | CPU memory write strobe |
| ram_rdata_i | input | 8 | Data returned by the RAM |
| phys_addr_o | output | 20 | Physical RAM address |
| ram_valid_o | output | 1 | Selected page is populated |
| ram_we_o | output | 1 | Gated RAM write enable |
| mem_rdata_o | output | 8 | Memory read data, FFh for unpopulated pages |

## Verification
The assertions check the following on every cycle:
- the output-enable gating and the idle value of the read data;
- the FFh substitution and the dropped writes for unpopulated pages;
- that the window offset bits pass through unchanged;
- that a valid flag never accompanies a page at or above the installed count;
- that a port write lands in the register it addresses.

Other behaviours need the bench's scenarios. These are the reset contents, that non-mapper addresses leave every register untouched, and that the full written byte comes back on read-back. They also include the exact window-to-register mapping, the exact validity boundary for several installed sizes, and the mirroring of pages 40h and above. The bench shows these by sweeping every register value through every window.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int unsigned NUM_WIN     = 4;
  localparam int unsigned DATA_W      = 8;
  localparam int unsigned IO_AW       = 8;
  localparam int unsigned WIN_AW      = 14;
  localparam int unsigned PHYS_PAGE_W = 6;
  localparam int unsigned WIN_IDX_W   = $clog2(NUM_WIN);
  localparam int unsigned CPU_AW      = WIN_AW + WIN_IDX_W;
  localparam int unsigned PHYS_AW     = PHYS_PAGE_W + WIN_AW;
  localparam int unsigned CNT_W       = PHYS_PAGE_W + 1;
  localparam logic [IO_AW-1:0] PORT_BASE = 8'hFC;
endpackage

// File: rtl/mapper_port_decode.sv
module mapper_port_decode #(
  parameter int unsigned IO_AW = 8,
  parameter int unsigned NUM_WIN = 4,
  parameter logic [IO_AW-1:0] BASE = 8'hFC,
  localparam int unsigned IDX_W = $clog2(NUM_WIN)
) (
  input  logic [IO_AW-1:0] io_addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  assign hit_o = (io_addr_i[IO_AW-1:IDX_W] == BASE[IO_AW-1:IDX_W]);
  assign idx_o = io_addr_i[IDX_W-1:0];
endmodule

// File: rtl/mapper_page_regs.sv
module mapper_page_regs #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(NUM_WIN)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_idx_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [NUM_WIN-1:0][DATA_W-1:0] page_q_o
);
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_reg
    // descending reset pattern: first port holds the highest page
    localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(NUM_WIN - 1 - k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_q_o[k] <= RST_VAL;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(k))) begin
        page_q_o[k] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/mapper_addr_xlate.sv
module mapper_addr_xlate #(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned WIN_AW = 14,
  parameter int unsigned PHYS_PAGE_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(NUM_WIN),
  localparam int unsigned CPU_AW = WIN_AW + IDX_W,
  localparam int unsigned PHYS_AW = PHYS_PAGE_W + WIN_AW,
  localparam int unsigned CNT_W = PHYS_PAGE_W + 1
) (
  input  logic [NUM_WIN-1:0][PHYS_PAGE_W-1:0] page_lo_i,
  input  logic [CNT_W-1:0]                    cfg_pages_i,
  input  logic [CPU_AW-1:0]                   mem_addr_i,
  input  logic                                mem_wr_i,
  input  logic [DATA_W-1:0]                   ram_rdata_i,
  output logic [PHYS_AW-1:0]                  phys_addr_o,
  output logic                                ram_valid_o,
  output logic                                ram_we_o,
  output logic [DATA_W-1:0]                   mem_rdata_o
);
  logic [IDX_W-1:0]       win;
  logic [PHYS_PAGE_W-1:0] cur_page;

  assign win         = mem_addr_i[CPU_AW-1 -: IDX_W];
  assign cur_page    = page_lo_i[win];
  assign phys_addr_o = {cur_page, mem_addr_i[WIN_AW-1:0]};
  assign ram_valid_o = ({1'b0, cur_page} < cfg_pages_i);
  assign ram_we_o    = mem_wr_i & ram_valid_o;
  assign mem_rdata_o = ram_valid_o ? ram_rdata_i : {DATA_W{1'b1}};
endmodule

// File: rtl/mapper_page_unit.sv
module mapper_page_unit
  import mapper_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CNT_W-1:0]       cfg_pages_i,
  input  logic                   cfg_rd_en_i,
  input  logic [IO_AW-1:0]       io_addr_i,
  input  logic                   io_wr_i,
  input  logic                   io_rd_i,
  input  logic [DATA_W-1:0]      io_wdata_i,
  output logic [DATA_W-1:0]      io_rdata_o,
  output logic                   io_oe_o,
  input  logic [CPU_AW-1:0]      mem_addr_i,
  input  logic                   mem_wr_i,
  input  logic [DATA_W-1:0]      ram_rdata_i,
  output logic [PHYS_AW-1:0]     phys_addr_o,
  output logic                   ram_valid_o,
  output logic                   ram_we_o,
  output logic [DATA_W-1:0]      mem_rdata_o
);
  logic                                io_hit;
  logic [WIN_IDX_W-1:0]                io_idx;
  logic [NUM_WIN-1:0][DATA_W-1:0]      page_q;
  logic [NUM_WIN-1:0][PHYS_PAGE_W-1:0] page_lo;

  mapper_port_decode #(
    .IO_AW(IO_AW), .NUM_WIN(NUM_WIN), .BASE(PORT_BASE)
  ) u_dec (
    .io_addr_i(io_addr_i),
    .hit_o    (io_hit),
    .idx_o    (io_idx)
  );

  mapper_page_regs #(
    .NUM_WIN(NUM_WIN), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (io_wr_i & io_hit),
    .wr_idx_i (io_idx),
    .wr_data_i(io_wdata_i),
    .page_q_o (page_q)
  );

  // upper page bits only mirror: strip them before translation
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_mask
    assign page_lo[k] = page_q[k][PHYS_PAGE_W-1:0];
  end

  mapper_addr_xlate #(
    .NUM_WIN(NUM_WIN), .WIN_AW(WIN_AW), .PHYS_PAGE_W(PHYS_PAGE_W), .DATA_W(DATA_W)
  ) u_xlate (
    .page_lo_i  (page_lo),
    .cfg_pages_i(cfg_pages_i),
    .mem_addr_i (mem_addr_i),
    .mem_wr_i   (mem_wr_i),
    .ram_rdata_i(ram_rdata_i),
    .phys_addr_o(phys_addr_o),
    .ram_valid_o(ram_valid_o),
    .ram_we_o   (ram_we_o),
    .mem_rdata_o(mem_rdata_o)
  );

  // full byte or nothing: never force unused bits high
  assign io_oe_o    = io_rd_i & io_hit & cfg_rd_en_i;
  assign io_rdata_o = io_oe_o ? page_q[io_idx] : '0;
endmodule

// File: rtl/mapper_page_unit_chk.sv
module mapper_page_unit_chk
  import mapper_pkg::*;
(
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [CNT_W-1:0]               cfg_pages_i,
  input logic                           cfg_rd_en_i,
  input logic [IO_AW-1:0]               io_addr_i,
  input logic                           io_wr_i,
  input logic                           io_rd_i,
  input logic [DATA_W-1:0]              io_wdata_i,
  input logic [DATA_W-1:0]              io_rdata_o,
  input logic                           io_oe_o,
  input logic [CPU_AW-1:0]              mem_addr_i,
  input logic                           mem_wr_i,
  input logic [PHYS_AW-1:0]             phys_addr_o,
  input logic                           ram_valid_o,
  input logic                           ram_we_o,
  input logic [DATA_W-1:0]              mem_rdata_o,
  input logic [NUM_WIN-1:0][DATA_W-1:0] page_q
);
  logic port_match;
  assign port_match = (io_addr_i[IO_AW-1:WIN_IDX_W] == PORT_BASE[IO_AW-1:WIN_IDX_W]);

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && port_match) |=> (page_q[$past(io_addr_i[WIN_IDX_W-1:0])] == $past(io_wdata_i)));

  assert_oe_needs_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> (cfg_rd_en_i && io_rd_i && port_match));

  assert_idle_data_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_oe_o |-> (io_rdata_o == '0));

  assert_offset_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[WIN_AW-1:0] == mem_addr_i[WIN_AW-1:0]);

  assert_valid_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_valid_o |-> ({1'b0, phys_addr_o[PHYS_AW-1:WIN_AW]} < cfg_pages_i));

  assert_unpop_reads_ff_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_valid_o |-> (mem_rdata_o == {DATA_W{1'b1}}));

  assert_we_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (mem_wr_i && ram_valid_o));
endmodule

bind mapper_page_unit mapper_page_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_pages_i(cfg_pages_i),
  .cfg_rd_en_i(cfg_rd_en_i),
  .io_addr_i  (io_addr_i),
  .io_wr_i    (io_wr_i),
  .io_rd_i    (io_rd_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .io_oe_o    (io_oe_o),
  .mem_addr_i (mem_addr_i),
  .mem_wr_i   (mem_wr_i),
  .phys_addr_o(phys_addr_o),
  .ram_valid_o(ram_valid_o),
  .ram_we_o   (ram_we_o),
  .mem_rdata_o(mem_rdata_o),
  .page_q     (page_q)
);

// File: tb/mapper_page_unit_test.sv
module mapper_page_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  cfg_pages = 7'd48;
  logic        cfg_rd_en = 1'b1;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_oe;
  logic [15:0] mem_addr = '0;
  logic        mem_wr = 1'b0;
  logic [7:0]  ram_rdata = '0;
  logic [19:0] phys_addr;
  logic        ram_valid, ram_we;
  logic [7:0]  mem_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mapper_page_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_pages_i(cfg_pages), .cfg_rd_en_i(cfg_rd_en),
    .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_oe_o(io_oe), .mem_addr_i(mem_addr), .mem_wr_i(mem_wr),
    .ram_rdata_i(ram_rdata), .phys_addr_o(phys_addr), .ram_valid_o(ram_valid),
    .ram_we_o(ram_we), .mem_rdata_o(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  // combinational read, sampled mid-cycle
  task automatic io_read(input logic [7:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    d = io_rdata; oe = io_oe;
    io_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    logic [7:0] shadow [4];
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    for (int k = 0; k < 4; k++) begin
      io_read(8'hFC + 8'(k), d, oe);
      chk("R1 reset value", {24'd0, d}, 32'(3 - k));
      chk("R3 oe on read", {31'd0, oe}, 32'd1);
      shadow[k] = 8'(3 - k);
    end

    // R2/R3 exhaustive write/readback per port
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 256; v++) begin
        io_write(8'hFC + 8'(k), 8'(v));
        io_read(8'hFC + 8'(k), d, oe);
        chk("R3 full byte readback", {24'd0, d}, 32'(v));
      end
      shadow[k] = 8'hFF;
    end

    // R2 non-mapper addresses leave registers untouched
    for (int a = 0; a < 252; a++) begin
      io_write(8'(a), 8'(a ^ 8'h5A));
    end
    for (int k = 0; k < 4; k++) begin
      io_read(8'hFC + 8'(k), d, oe);
      chk("R2 foreign write ignored", {24'd0, d}, {24'd0, shadow[k]});
    end

    // R4 gating of output enable
    io_read(8'hFB, d, oe);
    chk("R4 oe off outside range", {31'd0, oe}, 32'd0);
    chk("R4 data zero when idle", {24'd0, d}, 32'd0);
    cfg_rd_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      io_read(8'hFC + 8'(k), d, oe);
      chk("R4 oe off when disabled", {31'd0, oe}, 32'd0);
      chk("R4 data zero when disabled", {24'd0, d}, 32'd0);
    end
    @(negedge clk);
    io_addr = 8'hFE; io_rd = 1'b0; cfg_rd_en = 1'b1;
    #1 chk("R4 oe off without read", {31'd0, io_oe}, 32'd0);

    // R5..R9 translation sweep
    for (int c = 0; c < 4; c++) begin
      cfg_pages = (c == 0) ? 7'd48 : (c == 1) ? 7'd64 : (c == 2) ? 7'd7 : 7'd0;
      for (int w = 0; w < 4; w++) begin
        for (int p = 0; p < 256; p++) begin
          logic [5:0]  pl;
          logic [13:0] off;
          logic        v_exp;
          io_write(8'hFC + 8'(w), 8'(p));
          pl    = 6'(p % 64);
          off   = 14'((p * 37 + w * 4099) % 16384);
          v_exp = (32'(pl) < 32'(cfg_pages));
          @(negedge clk);
          mem_addr  = {2'(w), off};
          mem_wr    = 1'b1;
          ram_rdata = 8'(p) ^ 8'hA5;
          #1;
          chk("R5 phys addr", {12'd0, phys_addr}, 32'(pl) * 16384 + 32'(off));
          chk("R6 R9 valid flag", {31'd0, ram_valid}, {31'd0, v_exp});
          chk("R7 mem read data", {24'd0, mem_rdata},
              v_exp ? {24'd0, 8'(p) ^ 8'hA5} : 32'hFF);
          chk("R8 gated write", {31'd0, ram_we}, {31'd0, v_exp});
          mem_wr = 1'b0;
          #1 chk("R8 no write when idle", {31'd0, ram_we}, 32'd0);
        end
      end
    end

    // R9 readback keeps bits 7:6 while translation mirrors
    io_write(8'hFD, 8'hC2);
    io_read(8'hFD, d, oe);
    chk("R9 high bits read back", {24'd0, d}, 32'hC2);
    cfg_pages = 7'd3;
    @(negedge clk);
    mem_addr = 16'h4123;
    #1;
    chk("R9 mirror phys addr", {12'd0, phys_addr}, 32'h2 * 16384 + 32'h0123);
    chk("R9 mirror valid", {31'd0, ram_valid}, 32'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule